// File: doc/BRIEF.md
# Fused Read-Modify-Write ALU

This execution unit serves an 8-bit accumulator machine that has compound instructions. A compound instruction changes a memory operand, returns the changed byte for write-back, and in the same step merges that byte into the accumulator, the index register or the stack pointer. The sequencer presents an operation code, the fetched byte, the current A, X and SP, the high byte of the effective address and the incoming C, Z, N and V flags, and raises `start` for one cycle. On the next cycle `done` is high for one cycle. At the same time the unit shows the write-back byte with its enable, the new register values with one enable per register, and the complete new flag set.

The carry chain is chained across two steps. The memory step (shift, rotate, increment or decrement) produces an intermediate carry or value. The register step (OR, XOR, AND, add, subtract or compare) then consumes it. One adder is shared by every arithmetic operation. The data width is a parameter. A second parameter chooses between an explicit ripple adder and an inferred adder.

Top module: `rmw_fused_alu`

## Requirements
- R1: While `rst_n` is low, every output is 0 and `done` is 0.
- R2: `start` is sampled on a rising clock edge. Results appear after that edge, and `done` is high for exactly one cycle per accepted start. The enables `mem_we`, `a_we`, `x_we` and `sp_we` are high only while `done` is high. Data and flag outputs hold their values between starts. In the result cycle, a register that the operation does not write shows its input value, `mem_wdata` shows `mem_rdata` when memory is not written, and flags that the operation does not name show their inputs.
- R3: Code 0 (shift-left-or) writes the operand shifted left by one to memory and sets A to A OR that byte. C becomes the operand's old top bit, and N and Z follow the new A.
- R4: Code 1 (shift-right-xor) writes the operand shifted right by one, with a zero entering at the top, to memory and sets A to A XOR that byte. C becomes the operand's old bit 0, and N and Z follow the new A.
- R5: Code 2 (rotate-left-and) writes the operand shifted left with the incoming C in bit 0 to memory and sets A to A AND that byte. C becomes the old top bit, and N and Z follow the new A.
- R6: Code 3 (rotate-right-add) writes the operand shifted right with the incoming C in the top bit to memory. It then adds A, the rotated byte and the operand's old bit 0 as carry-in. A takes the sum, C takes the carry out, V is set on signed overflow, and N and Z follow A.
- R7: Code 4 (decrement-compare) writes the operand minus one, wrapping from 0 to all ones. C is set when A is greater than or equal to the decremented byte. N and Z come from A minus that byte, A is not written, and V is unchanged.
- R8: Code 5 (increment-subtract) writes the operand plus one, wrapping from all ones to 0. A becomes A minus that byte minus (1 − C). C becomes 1 when no borrow occurs, V is set on signed overflow, and N and Z follow A.
- R9: Code 6 (load-pair) sets A and X to the operand, sets N and Z from it, and does not write memory. Code 7 (store-and) writes A AND X to memory and changes no register and no flag.
- R10: Code 8 (load-and-stack) sets A, X and SP all to the operand AND SP, sets N and Z from that value, and does not write memory.
- R11: Code 9 (stack-store) sets SP to A AND X and writes A AND X AND (address high byte + 1) to memory, where the increment wraps from all ones to 0. No flag changes.
- R12: Code 10 (index-subtract) sets X to (A AND X) minus the operand, wrapping. C is set when (A AND X) is greater than or equal to the operand, N and Z follow the new X, and V is unchanged. Memory is not written.
- R13: Codes 11 to 15 still pulse `done`, but raise no enable and pass every register, flag and the operand through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the presented operation |
| op_sel | input | 4 | Operation code (0 to 10 defined) |
| mem_rdata | input | DATA_W | Fetched memory operand |
| a_in | input | DATA_W | Current accumulator |
| x_in | input | DATA_W | Current index register |
| sp_in | input | DATA_W | Current stack pointer |
| addr_hi | input | DATA_W | High byte of the effective address |
| c_in | input | 1 | Incoming carry |
| z_in | input | 1 | Incoming zero flag |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| done | output | 1 | One-cycle result strobe |
| mem_we | output | 1 | Write-back enable |
| mem_wdata | output | DATA_W | Write-back byte |
| a_we | output | 1 | Accumulator update enable |
| a_out | output | DATA_W | New accumulator |
| x_we | output | 1 | Index update enable |
| x_out | output | DATA_W | New index register |
| sp_we | output | 1 | Stack pointer update enable |
| sp_out | output | DATA_W | New stack pointer |
| c_out | output | 1 | New carry |
| z_out | output | 1 | New zero flag |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |

## Verification
The only state is the output register bank, so every internal fault shows up in the single `done` cycle that follows the start that exposes it. A wrong shift carry or a wrong adder operand select appears as a wrong C, V or accumulator in that cycle. It is most visible when the intermediate carry of the first step is the only thing that can change the sum. A stuck enable or a bad pass-through shows up either as a register changing on an operation that should leave it alone, or as an enable still high one cycle after `done`.

// File: rtl/rmw_fused_pkg.sv
package rmw_fused_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_SHL_OR    = 4'd0,
      OP_SHR_XOR   = 4'd1,
      OP_ROL_AND   = 4'd2,
      OP_ROR_ADC   = 4'd3,
      OP_DEC_CMP   = 4'd4,
      OP_INC_SBC   = 4'd5,
      OP_LD_AX     = 4'd6,
      OP_ST_AX     = 4'd7,
      OP_LD_AND_SP = 4'd8,
      OP_ST_SP_AX  = 4'd9,
      OP_X_SUB     = 4'd10
   } op_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } flags_t;
endpackage

// File: rtl/rmw_mem_stage.sv
module rmw_mem_stage
   import rmw_fused_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] x_val,
   input  logic [DATA_W-1:0] addr_hi,
   input  logic              carry_in,
   output logic [DATA_W-1:0] mem_val,
   output logic              shift_c,
   output logic              mem_we
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      mem_val = opnd;
      shift_c = carry_in;
      mem_we  = 1'b0;
      case (op)
         OP_SHL_OR: begin
            mem_val = {opnd[MSB-1:0], 1'b0};
            shift_c = opnd[MSB];
            mem_we  = 1'b1;
         end
         OP_SHR_XOR: begin
            mem_val = {1'b0, opnd[MSB:1]};
            shift_c = opnd[0];
            mem_we  = 1'b1;
         end
         OP_ROL_AND: begin
            mem_val = {opnd[MSB-1:0], carry_in};
            shift_c = opnd[MSB];
            mem_we  = 1'b1;
         end
         OP_ROR_ADC: begin
            mem_val = {carry_in, opnd[MSB:1]};
            shift_c = opnd[0];
            mem_we  = 1'b1;
         end
         OP_DEC_CMP: begin
            mem_val = opnd - DATA_W'(1);
            mem_we  = 1'b1;
         end
         OP_INC_SBC: begin
            mem_val = opnd + DATA_W'(1);
            mem_we  = 1'b1;
         end
         OP_ST_AX: begin
            mem_val = a_val & x_val;
            mem_we  = 1'b1;
         end
         OP_ST_SP_AX: begin
            mem_val = a_val & x_val & (addr_hi + DATA_W'(1));
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rmw_shared_adder.sv
module rmw_shared_adder #(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] cy;
         always_comb begin
            cy[0] = cin;
            for (int i = 0; i < DATA_W; i++) begin
               sum[i]   = lhs[i] ^ rhs[i] ^ cy[i];
               cy[i+1]  = (lhs[i] & rhs[i]) | (cy[i] & (lhs[i] ^ rhs[i]));
            end
            cout = cy[DATA_W];
            ovf  = cy[DATA_W] ^ cy[MSB];
         end
      end else begin : g_infer
         always_comb begin
            {cout, sum} = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
            ovf = (lhs[MSB] == rhs[MSB]) && (sum[MSB] != lhs[MSB]);
         end
      end
   endgenerate

   always_comb begin
      if (!$isunknown({lhs, rhs, cin}))
         AST_ADDER_SUM: assert ({cout, sum} == ({1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin}))
            else $error("adder sum mismatch"); // R6
   end
endmodule

// File: rtl/rmw_fused_alu.sv
module rmw_fused_alu
   import rmw_fused_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] addr_hi,
   input  logic              c_in,
   input  logic              z_in,
   input  logic              n_in,
   input  logic              v_in,
   output logic              done,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              a_we,
   output logic [DATA_W-1:0] a_out,
   output logic              x_we,
   output logic [DATA_W-1:0] x_out,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_out,
   output logic              c_out,
   output logic              z_out,
   output logic              n_out,
   output logic              v_out
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   op_e               op;
   flags_t            f_in, f_nx;
   logic [DATA_W-1:0] mem_val, ad_l, ad_r, ad_sum;
   logic [DATA_W-1:0] a_nx, x_nx, sp_nx, and_tmp;
   logic              shift_c, mem_en, ad_ci, ad_cout, ad_ovf;
   logic              a_en, x_en, sp_en;

   assign op   = op_e'(op_sel);
   assign f_in = '{c: c_in, z: z_in, n: n_in, v: v_in};

   function automatic flags_t with_nz(flags_t f, logic [DATA_W-1:0] r);
      f.n = r[MSB];
      f.z = (r == '0);
      return f;
   endfunction

   rmw_mem_stage #(.DATA_W(DATA_W)) mem_stage_i (
      .op       (op),
      .opnd     (mem_rdata),
      .a_val    (a_in),
      .x_val    (x_in),
      .addr_hi  (addr_hi),
      .carry_in (c_in),
      .mem_val  (mem_val),
      .shift_c  (shift_c),
      .mem_we   (mem_en)
   );

   // one adder serves add, subtract and both compares
   always_comb begin
      ad_l  = a_in;
      ad_r  = ~mem_rdata;
      ad_ci = 1'b1;
      case (op)
         OP_ROR_ADC: begin ad_r = mem_val;  ad_ci = shift_c; end
         OP_INC_SBC: begin ad_r = ~mem_val; ad_ci = c_in;    end
         OP_DEC_CMP: ad_r = ~mem_val;
         OP_X_SUB:   ad_l = a_in & x_in;
         default: ;
      endcase
   end

   rmw_shared_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE_ADD)) adder_i (
      .lhs  (ad_l),
      .rhs  (ad_r),
      .cin  (ad_ci),
      .sum  (ad_sum),
      .cout (ad_cout),
      .ovf  (ad_ovf)
   );

   always_comb begin
      a_nx    = a_in;
      x_nx    = x_in;
      sp_nx   = sp_in;
      f_nx    = f_in;
      a_en    = 1'b0;
      x_en    = 1'b0;
      sp_en   = 1'b0;
      and_tmp = mem_rdata & sp_in;
      case (op)
         OP_SHL_OR: begin
            a_nx = a_in | mem_val; a_en = 1'b1;
            f_nx.c = shift_c; f_nx = with_nz(f_nx, a_nx);
         end
         OP_SHR_XOR: begin
            a_nx = a_in ^ mem_val; a_en = 1'b1;
            f_nx.c = shift_c; f_nx = with_nz(f_nx, a_nx);
         end
         OP_ROL_AND: begin
            a_nx = a_in & mem_val; a_en = 1'b1;
            f_nx.c = shift_c; f_nx = with_nz(f_nx, a_nx);
         end
         OP_ROR_ADC, OP_INC_SBC: begin
            a_nx = ad_sum; a_en = 1'b1;
            f_nx.c = ad_cout; f_nx.v = ad_ovf; f_nx = with_nz(f_nx, a_nx);
         end
         OP_DEC_CMP: begin
            f_nx.c = ad_cout; f_nx = with_nz(f_nx, ad_sum);
         end
         OP_LD_AX: begin
            a_nx = mem_rdata; x_nx = mem_rdata; a_en = 1'b1; x_en = 1'b1;
            f_nx = with_nz(f_nx, mem_rdata);
         end
         OP_LD_AND_SP: begin
            a_nx = and_tmp; x_nx = and_tmp; sp_nx = and_tmp;
            a_en = 1'b1; x_en = 1'b1; sp_en = 1'b1;
            f_nx = with_nz(f_nx, and_tmp);
         end
         OP_ST_SP_AX: begin
            sp_nx = a_in & x_in; sp_en = 1'b1;
         end
         OP_X_SUB: begin
            x_nx = ad_sum; x_en = 1'b1;
            f_nx.c = ad_cout; f_nx = with_nz(f_nx, ad_sum);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0; mem_we <= 1'b0; a_we <= 1'b0; x_we <= 1'b0; sp_we <= 1'b0;
         mem_wdata <= '0; a_out <= '0; x_out <= '0; sp_out <= '0;
         c_out <= 1'b0; z_out <= 1'b0; n_out <= 1'b0; v_out <= 1'b0;
      end else if (start) begin
         done      <= 1'b1;
         mem_we    <= mem_en;
         a_we      <= a_en;
         x_we      <= x_en;
         sp_we     <= sp_en;
         mem_wdata <= mem_val;
         a_out     <= a_nx;
         x_out     <= x_nx;
         sp_out    <= sp_nx;
         {c_out, z_out, n_out, v_out} <= f_nx;
      end else begin
         done <= 1'b0; mem_we <= 1'b0; a_we <= 1'b0; x_we <= 1'b0; sp_we <= 1'b0;
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start)) else $error("done without start"); // R2
   AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || a_we || x_we || sp_we) |-> done) else $error("enable outside done"); // R2
   AST_DEC_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == OP_DEC_CMP) |=> (!a_we && mem_we && a_out == $past(a_in)))
      else $error("compare touched A"); // R7
   AST_LOADS_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op == OP_LD_AX || op == OP_LD_AND_SP || op == OP_X_SUB)) |=> !mem_we)
      else $error("load wrote memory"); // R9
   AST_STACK_STORE_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == OP_ST_SP_AX) |=> (sp_we && mem_we && !a_we && !x_we))
      else $error("stack store enables"); // R11
   AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_sel > 4'd10) |=> (done && !mem_we && !a_we && !x_we && !sp_we))
      else $error("unused code wrote"); // R13
endmodule

// File: tb/rmw_fused_alu_tb.sv
module rmw_fused_alu_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] mem_rdata = '0, a_in = '0, x_in = '0, sp_in = '0, addr_hi = '0;
   logic       c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
   logic       done, mem_we, a_we, x_we, sp_we, c_out, z_out, n_out, v_out;
   logic [7:0] mem_wdata, a_out, x_out, sp_out;
   int         checks = 0;
   int         fails = 0;

   always #4 clk = ~clk;

   rmw_fused_alu dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .mem_rdata(mem_rdata), .a_in(a_in), .x_in(x_in), .sp_in(sp_in), .addr_hi(addr_hi),
      .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
      .done(done), .mem_we(mem_we), .mem_wdata(mem_wdata), .a_we(a_we), .a_out(a_out),
      .x_we(x_we), .x_out(x_out), .sp_we(sp_we), .sp_out(sp_out),
      .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out)
   );

   function automatic logic [39:0] bundle_now();
      return {mem_we, mem_wdata, a_we, a_out, x_we, x_out, sp_we, sp_out,
              c_out, z_out, n_out, v_out};
   endfunction

   // expected result from the requirement text
   function automatic logic [39:0] model(logic [3:0] op, logic [7:0] m, logic [7:0] a,
                                         logic [7:0] x, logic [7:0] sp, logic [7:0] hi,
                                         logic c, logic z, logic n, logic v);
      logic mwe, awe, xwe, swe;
      logic [7:0] mw, ao, xo, so, r;
      logic [8:0] t;
      mwe = 0; awe = 0; xwe = 0; swe = 0;
      mw = m; ao = a; xo = x; so = sp; r = 8'h00; t = 9'h000;
      case (op)
         4'd0: begin mw = m << 1; mwe = 1; ao = a | mw; awe = 1; c = m[7]; n = ao[7]; z = (ao == 0); end
         4'd1: begin mw = m >> 1; mwe = 1; ao = a ^ mw; awe = 1; c = m[0]; n = ao[7]; z = (ao == 0); end
         4'd2: begin mw = {m[6:0], c}; mwe = 1; ao = a & mw; awe = 1; c = m[7]; n = ao[7]; z = (ao == 0); end
         4'd3: begin
            mw = {c, m[7:1]}; mwe = 1;
            t = {1'b0, a} + {1'b0, mw} + {8'h00, m[0]};
            ao = t[7:0]; awe = 1; c = t[8];
            v = (a[7] == mw[7]) && (ao[7] != a[7]); n = ao[7]; z = (ao == 0);
         end
         4'd4: begin mw = m - 8'd1; mwe = 1; c = (a >= mw); r = a - mw; n = r[7]; z = (r == 0); end
         4'd5: begin
            mw = m + 8'd1; mwe = 1;
            t = {1'b0, a} - {1'b0, mw} - {8'h00, ~c};
            ao = t[7:0]; awe = 1; c = ~t[8];
            v = (a[7] != mw[7]) && (ao[7] != a[7]); n = ao[7]; z = (ao == 0);
         end
         4'd6: begin ao = m; xo = m; awe = 1; xwe = 1; n = m[7]; z = (m == 0); end
         4'd7: begin mw = a & x; mwe = 1; end
         4'd8: begin r = m & sp; ao = r; xo = r; so = r; awe = 1; xwe = 1; swe = 1; n = r[7]; z = (r == 0); end
         4'd9: begin so = a & x; swe = 1; mw = a & x & (hi + 8'd1); mwe = 1; end
         4'd10: begin r = a & x; xo = r - m; xwe = 1; c = (r >= m); n = xo[7]; z = (xo == 0); end
         default: ;
      endcase
      return {mwe, mw, awe, ao, xwe, xo, swe, so, c, z, n, v};
   endfunction

   task automatic check(string req, logic [39:0] act, logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(string req, logic [3:0] op, logic [7:0] m, logic [7:0] a,
                         logic [7:0] x, logic [7:0] sp, logic [7:0] hi, logic [3:0] f);
      logic [39:0] exp;
      exp = model(op, m, a, x, sp, hi, f[3], f[2], f[1], f[0]);
      @(negedge clk);
      op_sel = op; mem_rdata = m; a_in = a; x_in = x; sp_in = sp; addr_hi = hi;
      {c_in, z_in, n_in, v_in} = f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2", {39'h0, done}, 40'h1);
      check(req, bundle_now(), exp);
      @(negedge clk);
      check("R2", {36'h0, done, mem_we, a_we, x_we, sp_we}, 40'h0);
   endtask

   task automatic t_reset();
      check("R1", {39'h0, done}, 40'h0);
      check("R1", bundle_now(), 40'h0);
   endtask

   task automatic t_shl_or();   // R3
      run_op("R3", 4'd0, 8'h81, 8'h10, 8'h00, 8'h00, 8'h00, 4'b0000);
      run_op("R3", 4'd0, 8'h40, 8'h00, 8'h33, 8'h44, 8'h00, 4'b1001);
   endtask

   task automatic t_shr_xor();  // R4
      run_op("R4", 4'd1, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 4'b0000);
      run_op("R4", 4'd1, 8'hFE, 8'hFF, 8'h12, 8'h00, 8'h00, 4'b1000);
   endtask

   task automatic t_rol_and();  // R5
      run_op("R5", 4'd2, 8'h80, 8'hFF, 8'h00, 8'h00, 8'h00, 4'b1000);
      run_op("R5", 4'd2, 8'h55, 8'hAA, 8'h00, 8'h00, 8'h00, 4'b0000);
   endtask

   task automatic t_ror_adc();  // R6
      run_op("R6", 4'd3, 8'h01, 8'h80, 8'h00, 8'h00, 8'h00, 4'b1000);
      run_op("R6", 4'd3, 8'h02, 8'h7F, 8'h00, 8'h00, 8'h00, 4'b0000);
      run_op("R6", 4'd3, 8'h10, 8'h05, 8'h00, 8'h00, 8'h00, 4'b0001);
   endtask

   task automatic t_dec_cmp();  // R7
      run_op("R7", 4'd4, 8'h00, 8'h10, 8'h22, 8'h00, 8'h00, 4'b1001);
      run_op("R7", 4'd4, 8'h11, 8'h10, 8'h00, 8'h00, 8'h00, 4'b0000);
   endtask

   task automatic t_inc_sbc();  // R8
      run_op("R8", 4'd5, 8'hFF, 8'h50, 8'h00, 8'h00, 8'h00, 4'b1000);
      run_op("R8", 4'd5, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000);
      run_op("R8", 4'd5, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00, 4'b1000);
   endtask

   task automatic t_load_store(); // R9
      run_op("R9", 4'd6, 8'h00, 8'h12, 8'h34, 8'h56, 8'h00, 4'b1001);
      run_op("R9", 4'd7, 8'h99, 8'hF0, 8'h3C, 8'h56, 8'h00, 4'b1011);
   endtask

   task automatic t_ld_and_sp(); // R10
      run_op("R10", 4'd8, 8'hF3, 8'h00, 8'h00, 8'h8F, 8'h00, 4'b1001);
   endtask

   task automatic t_stack_store(); // R11
      run_op("R11", 4'd9, 8'h00, 8'hFF, 8'h7E, 8'h10, 8'hFF, 4'b0110);
      run_op("R11", 4'd9, 8'h00, 8'hF7, 8'h7E, 8'h10, 8'h3C, 4'b0000);
   endtask

   task automatic t_x_sub();    // R12
      run_op("R12", 4'd10, 8'h05, 8'h0F, 8'hF3, 8'h00, 8'h00, 4'b0001);
      run_op("R12", 4'd10, 8'h03, 8'h0F, 8'hF3, 8'h00, 8'h00, 4'b0000);
   endtask

   task automatic t_unused();   // R13
      run_op("R13", 4'd11, 8'h5A, 8'h11, 8'h22, 8'h33, 8'hFF, 4'b1010);
      run_op("R13", 4'd15, 8'hA5, 8'h44, 8'h55, 8'h66, 8'h00, 4'b0101);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_shl_or();
      t_shr_xor();
      t_rol_and();
      t_ror_adc();
      t_dec_cmp();
      t_inc_sbc();
      t_load_store();
      t_ld_and_sp();
      t_stack_store();
      t_x_sub();
      t_unused();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule